// File: doc/BRIEF.md
# Soft-Ramped Digital Volume Attenuator

This block scales signed PCM samples ahead of a DAC, with one gain stage per channel. Each channel takes an 8-bit target code. The code gives a linear gain of level/255: code 255 passes the sample unchanged and code 0 mutes it. The gain never jumps to a new code. Each channel keeps its own applied level, and that level walks toward the target one step at a time. The dwell on each step is a number of frame periods, and the speed mode selects that number.

The frame strobe is a one-cycle pulse, one per sample frame (LRCK boundary). The applied level can change only on a clock cycle that carries this strobe, so every sample of a frame sees the same gain. Samples are presented on every clock. The scaled result appears registered on the next clock edge.

Top module: `vol_soft_ramp`

## Requirements
- R1: After reset, every channel's applied level is 255, so each output equals its input sample delayed by one clock.
- R2: The output is sample × level / 255, truncated toward zero. Level 0 gives an output of exactly 0.
- R3: Each channel has its own target, level and dwell counter. Activity on one channel does not change another channel's output.
- R4: The applied level moves by at most one step per change, always toward the target, and never overshoots the target.
- R5: One step lasts 4 frame strobes for speed code 0, 8 for code 1, and 16 for code 2 or 3. A full 255-to-0 ramp therefore takes 1020, 2040 or 4080 strobes.
- R6: The applied level changes only on clock cycles where frame_tick is high.
- R7: A target change in the middle of a ramp continues the ramp from the current level toward the new target, with no jump.
- R8: An output sample depends on the input sample of the previous cycle. Its magnitude never exceeds that input's magnitude, and it is clamped to the sample width.
- R9: While the level equals the target, the level holds and the dwell counter is cleared. The first step after a new target therefore comes on the full interval's last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse per sample frame |
| speed | input | 2 | 0 normal, 1 double, 2/3 quad |
| target | input | NCH*8 | Per-channel attenuation code, channel 0 in low bits |
| sample_in | input | NCH*DW | Signed input samples, channel 0 in low bits |
| sample_out | output | NCH*DW | Signed scaled samples, one clock later |

## Verification
A sample presented before a clock edge is scaled with the level held before that edge. The result is at the outputs just after the edge. A level step is taken on a strobed edge, so it first affects the samples presented after that edge. The bench follows this order. It drives inputs shortly after an edge and compares the outputs shortly after the next edge against the model value computed before it. Only then does it advance its level model. The ramp duration checks count strobes up to the first output that carries the new target's gain. That output is one clock after the final strobe.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
    localparam int LVL_W = 8;
    localparam int CNT_W = 4;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [CNT_W-1:0] cnt;
    } ramp_st_t;

    // last dwell count value before a step is taken
    function automatic logic [CNT_W-1:0] dwell_last(input logic [1:0] spd);
        case (spd)
            2'd0:    return CNT_W'(3);
            2'd1:    return CNT_W'(7);
            default: return CNT_W'(15);
        endcase
    endfunction
endpackage

// File: rtl/vsr_ramp.sv
module vsr_ramp
    import vsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic [1:0]       speed,
    input  logic [LVL_W-1:0] target,
    output logic [LVL_W-1:0] level
);
    ramp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_tick) begin
            if (st_q.level == target) begin
                st_d.cnt = '0;
            end else if (st_q.cnt >= dwell_last(speed)) begin
                st_d.cnt = '0;
                if (st_q.level < target) st_d.level = st_q.level + 1'b1;
                else                     st_d.level = st_q.level - 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= LVL_MAX;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;

    assert_only_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(level));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> ({1'b0, level} == {1'b0, $past(level)}) ||
                       ({1'b0, level} == {1'b0, $past(level)} + 9'd1) ||
                       ({1'b0, level} + 9'd1 == {1'b0, $past(level)}));

    assert_no_overshoot_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && level < target) |=> (level <= $past(target)));

    assert_no_overshoot_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && level > target) |=> (level >= $past(target)));

    assert_hold_at_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && level == target) |=> $stable(level));
endmodule

// File: rtl/vsr_scale.sv
module vsr_scale
    import vsr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] sample_in,
    input  logic [LVL_W-1:0]     level,
    output logic signed [DW-1:0] sample_out
);
    localparam int PW = DW + LVL_W + 1;
    localparam logic signed [PW-1:0] DIVISOR = PW'(255);
    localparam logic signed [PW-1:0] POS_LIM = PW'((2 ** (DW - 1)) - 1);
    localparam logic signed [PW-1:0] NEG_LIM = -POS_LIM - PW'(1);

    logic signed [PW-1:0] prod, quot;
    logic signed [DW-1:0] out_d, out_q;

    always_comb begin
        prod = PW'(sample_in) * $signed({1'b0, level});
        quot = prod / DIVISOR;
        if (quot > POS_LIM)      out_d = POS_LIM[DW-1:0];
        else if (quot < NEG_LIM) out_d = NEG_LIM[DW-1:0];
        else                     out_d = quot[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sample_out = out_q;

    function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
        return v[DW-1] ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
    endfunction

    assert_no_gain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mag(sample_out) <= mag($past(sample_in)));

    assert_mute_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level == '0 |=> sample_out == '0);

    assert_unity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level == LVL_MAX |=> sample_out == $past(sample_in));
endmodule

// File: rtl/vol_soft_ramp.sv
module vol_soft_ramp
    import vsr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_tick,
    input  logic [1:0]             speed,
    input  logic [NCH*LVL_W-1:0]   target,
    input  logic [NCH*DW-1:0]      sample_in,
    output logic [NCH*DW-1:0]      sample_out
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [LVL_W-1:0] lvl;

        vsr_ramp i_ramp (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_tick (frame_tick),
            .speed      (speed),
            .target     (target[c*LVL_W +: LVL_W]),
            .level      (lvl)
        );

        vsr_scale #(.DW(DW)) i_scale (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_in  (sample_in[c*DW +: DW]),
            .level      (lvl),
            .sample_out (sample_out[c*DW +: DW])
        );
    end
endmodule

// File: tb/test_vol_soft_ramp.sv
module test_vol_soft_ramp;
    localparam int NCH = 2;
    localparam int DW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0;
    logic [1:0] speed = 2'd0;
    logic [NCH*8-1:0] target = '1;
    logic [NCH*DW-1:0] sample_in = '0;
    logic [NCH*DW-1:0] sample_out;

    int total = 0, bad = 0;
    int mlev[NCH];
    int mcnt[NCH];
    int cyc_n = 0;
    bit rnd = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    vol_soft_ramp #(.NCH(NCH), .DW(DW)) i_vol_soft_ramp (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .speed(speed),
        .target(target), .sample_in(sample_in), .sample_out(sample_out)
    );

    function automatic int expv(int s, int l);
        return (s * l) / 255;
    endfunction

    function automatic int dwell(int sp);
        return (sp == 0) ? 4 : (sp == 1) ? 8 : 16;
    endfunction

    function automatic int outv(int c);
        return int'($signed(sample_out[c*DW +: DW]));
    endfunction

    function automatic int inv(int c);
        return int'($signed(sample_in[c*DW +: DW]));
    endfunction

    task automatic check(string r, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // one clock: inputs are already driven; compare after the edge
    task automatic cyc();
        int e[NCH];
        for (int c = 0; c < NCH; c++) e[c] = expv(inv(c), mlev[c]);
        @(posedge clk);
        if (frame_tick) begin
            for (int c = 0; c < NCH; c++) begin
                int t = int'(target[c*8 +: 8]);
                if (mlev[c] == t) mcnt[c] = 0;
                else if (mcnt[c] >= dwell(int'(speed)) - 1) begin
                    mcnt[c] = 0;
                    mlev[c] += (mlev[c] < t) ? 1 : -1;
                end else mcnt[c]++;
            end
        end
        #1;
        for (int c = 0; c < NCH; c++) check(tag, outv(c), e[c]);
        cyc_n++;
        frame_tick = (cyc_n % 3 == 0);
        if (rnd) sample_in = {$urandom, $urandom};
        else     sample_in = {16'sh8000, 16'sh7fff};
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // count strobes until channel 0 output shows the target's gain
    task automatic measure(string r, int tgt, int exp_ticks);
        int ticks = 0;
        rnd = 1'b0;
        sample_in = {16'sh8000, 16'sh7fff};
        target[7:0] = 8'(tgt);
        for (int i = 0; i < 20000; i++) begin
            if (frame_tick) ticks++;
            cyc();
            if (outv(0) == expv(32767, tgt)) break;
        end
        check(r, ticks, exp_ticks);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin mlev[c] = 255; mcnt[c] = 0; end
        sample_in = {16'sh8000, 16'sh7fff};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: unity after reset
        tag = "R1";
        check("R1 out0", outv(0), 0);
        rnd = 1'b1;
        run(40);

        // R5 normal speed full ramp 255->0, R2 mute
        tag = "R2";
        measure("R5 normal 255->0", 0, 1020);
        check("R2 mute ch0", outv(0), 0);
        // R3 channel 1 untouched
        check("R3 ch1 unity", outv(1), -32768);

        // R5 double speed 0->5, quad 5->2, code 3 acts as quad
        speed = 2'd1;
        tag = "R5";
        measure("R5 double 0->5", 5, 40);
        speed = 2'd2;
        measure("R5 quad 5->2", 2, 48);
        speed = 2'd3;
        measure("R5 code3 2->4", 4, 32);

        // R9 hold at target
        tag = "R9";
        run(60);
        check("R9 hold", outv(0), expv(32767, 4));

        // R7 retarget mid-ramp
        speed = 2'd0;
        tag = "R7";
        target[7:0] = 8'd100;
        run(3 * 4 * 10);
        target[7:0] = 8'd0;
        run(3 * 4 * 20);
        check("R7 model level reached", mlev[0] <= 14 ? 1 : 0, 1);
        run(3 * 4 * 30);

        // R4/R6/R8/R3 random samples and targets
        tag = "R8";
        rnd = 1'b1;
        for (int k = 0; k < 40; k++) begin
            target = 16'($urandom);
            speed = 2'($urandom);
            run(150);
        end
        tag = "R4";
        target = {8'd0, 8'd255};
        run(3000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule